// File: doc/BRIEF.md
# DMA Width-Conversion Packing Engine

This block is the data path and address generator of one DMA channel. It moves a programmed number of items between a peripheral-side port and a memory-side port whose widths are chosen independently as 8, 16 or 32 bits. When the source is narrower than the destination, successive source items are gathered byte by byte into a 4-byte staging register until a full destination word exists. When the source is wider, each source word is handed out as several narrower destination items, lowest byte first.

Each port presents a request with an address, a write flag and write data, and the attached agent completes the beat by raising an acknowledge (carrying read data for reads). The engine advances each port's address after every completed beat on that port, by the item size or, on the peripheral side only, optionally by a constant 4 bytes. A one-cycle completion pulse follows the final destination beat. A configuration that would leave the last destination word partly filled is refused at start.

Top module: `dma_pack_engine`

## Requirements
- R1: Size codes for `psize` and `msize` are 0 = 8 bit, 1 = 16 bit, 2 = 32 bit; all nine pairings transfer correctly. Port data is right-aligned: an item of W bytes occupies bits [8W-1:0] of `*_rdata` and `*_wdata`, and bytes above that in `*_rdata` are ignored.
- R2: Packing is little-endian: the byte stream formed by the source items in order (each item lowest byte first) fills destination lanes from bits [7:0] upward.
- R3: Unpacking a wide source word emits its bytes to narrower destination items starting at bits [7:0].
- R4: `count` is in peripheral items; the transfer moves exactly `count` times the peripheral size in bytes, i.e. that total divided by each port's item size in beats per port.
- R5: With `pfix` = 1 and `pinc` = 1 the peripheral address grows by 4 after each peripheral beat, for every peripheral width.
- R6: With `pfix` = 0 and `pinc` = 1 the peripheral address grows by the peripheral item size (1, 2 or 4).
- R7: With `minc` = 1 the memory address grows by the memory item size after each memory beat; both addresses start at `p_base` and `m_base`.
- R8: A port whose increment enable (`pinc`, `minc`) is 0 keeps its start address for every beat.
- R9: A start whose `count` is 0, whose size code is 3, or whose `count` is not a multiple of the width ratio when the peripheral is narrower than memory raises `cfg_err` for exactly one cycle after the start edge, leaves `busy` low and issues no request.
- R10: A destination request is raised only when the staging register holds at least one full destination item.
- R11: `done` is high for exactly one cycle, the cycle after the last destination beat is accepted; `busy` is high until then and low in the following cycle.
- R12: `start` and all configuration inputs are ignored while `busy` is high; the running transfer is unaffected.
- R13: `dir` = 0 reads the peripheral port (`p_we` = 0) and writes memory (`m_we` = 1); `dir` = 1 reads memory and writes the peripheral port. Only one port requests at a time.
- R14: After reset `busy`, `done`, `cfg_err`, `p_req` and `m_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| psize | input | 2 | Peripheral item size code |
| msize | input | 2 | Memory item size code |
| pinc | input | 1 | Peripheral address increment enable |
| minc | input | 1 | Memory address increment enable |
| pfix | input | 1 | Peripheral step fixed at 4 bytes |
| count | input | CNT_W | Items to move, in peripheral units |
| p_base | input | AW | Peripheral start address |
| m_base | input | AW | Memory start address |
| p_req | output | 1 | Peripheral beat request |
| p_we | output | 1 | Peripheral beat is a write |
| p_addr | output | AW | Peripheral beat address |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data |
| p_ack | input | 1 | Peripheral beat completes |
| m_req | output | 1 | Memory beat request |
| m_we | output | 1 | Memory beat is a write |
| m_addr | output | AW | Memory beat address |
| m_wdata | output | 32 | Memory write data |
| m_rdata | input | 32 | Memory read data |
| m_ack | input | 1 | Memory beat completes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | One-cycle rejection pulse |

## Verification
The bench targets the byte-lane order at each width boundary, where an engine with swapped lanes or a wrong fill pointer would deliver bytes out of order or repeat stale staging bytes, and fills unused read lanes with a marker so a design that fails to mask them corrupts the upper destination bytes. It checks the fixed 4-byte peripheral step against narrow widths, where a design stepping by item size would present byte-spaced addresses, and disabled increments, where a drifting address shows at once. It attempts counts that are not multiples of the width ratio, which a lax design would accept and then hang or write a half-filled word, and pulses start with altered settings mid-transfer, which a design not latching its configuration would follow. Completion is timed to the exact cycle, so an early, late or stretched done pulse is caught.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } eng_state_e;

  // Bytes per item for a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Peripheral address step: constant 4 when fixed mode is on
  function automatic logic [2:0] periph_step(input logic [1:0] sz, input logic fixed4);
    return fixed4 ? 3'd4 : size_bytes(sz);
  endfunction

  // Accept only configurations that never leave a partial destination word
  function automatic logic count_ok(input logic [1:0] psz, input logic [1:0] msz,
                                    input logic [31:0] cnt);
    logic [31:0] mask;
    if (psz == 2'd3 || msz == 2'd3 || cnt == 32'd0) return 1'b0;
    if (psz >= msz) return 1'b1;
    mask = (32'd1 << (msz - psz)) - 32'd1;
    return (cnt & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/dma_pack_cfg.sv
module dma_pack_cfg #(
  parameter int CNT_W = 16
) (
  input  logic [1:0]       psize,
  input  logic [1:0]       msize,
  input  logic [CNT_W-1:0] count,
  output logic             cfg_ok
);
  import dma_pack_pkg::*;

  assign cfg_ok = count_ok(psize, msize, 32'(count));

endmodule

// File: rtl/dma_pack_addr.sv
module dma_pack_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step_en,
  input  logic          adv,
  input  logic [2:0]    step,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               addr <= '0;
    else if (load)            addr <= base;
    else if (adv && step_en)  addr <= addr + AW'(step);
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(adv && step_en)) |=> $stable(addr)); // R8

endmodule

// File: rtl/dma_pack_stage.sv
module dma_pack_stage (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        put,
  input  logic [31:0] put_data,
  input  logic [2:0]  put_bytes,
  input  logic        take,
  input  logic [2:0]  take_bytes,
  output logic [31:0] out_data,
  output logic [2:0]  fill,
  output logic [2:0]  off,
  output logic        drain
);

  logic [31:0] lanes;
  logic [31:0] shifted;
  logic [3:0]  put_end;
  logic [3:0]  take_end;

  assign shifted  = put_data << {fill, 3'b000};
  assign put_end  = {1'b0, fill} + {1'b0, put_bytes};
  assign take_end = {1'b0, off} + {1'b0, take_bytes};
  assign drain    = take && (take_end >= {1'b0, fill});
  assign out_data = lanes >> {off, 3'b000};

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic hit;
    assign hit = put && (4'(k) >= {1'b0, fill}) && (4'(k) < put_end);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lanes[8*k +: 8] <= 8'h00;
      else if (hit) lanes[8*k +: 8] <= shifted[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= 3'd0;
      off  <= 3'd0;
    end else if (drain) begin
      fill <= 3'd0;
      off  <= 3'd0;
    end else begin
      if (put)  fill <= put_end[2:0];
      if (take) off  <= take_end[2:0];
    end
  end

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 3'd4); // R10
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    put |-> (put_end <= 4'd4)); // R2

endmodule

// File: rtl/dma_pack_engine.sv
module dma_pack_engine #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [1:0]       psize,
  input  logic [1:0]       msize,
  input  logic             pinc,
  input  logic             minc,
  input  logic             pfix,
  input  logic [CNT_W-1:0] count,
  input  logic [AW-1:0]    p_base,
  input  logic [AW-1:0]    m_base,
  output logic             p_req,
  output logic             p_we,
  output logic [AW-1:0]    p_addr,
  output logic [31:0]      p_wdata,
  input  logic [31:0]      p_rdata,
  input  logic             p_ack,
  output logic             m_req,
  output logic             m_we,
  output logic [AW-1:0]    m_addr,
  output logic [31:0]      m_wdata,
  input  logic [31:0]      m_rdata,
  input  logic             m_ack,
  output logic             busy,
  output logic             done,
  output logic             cfg_err
);
  import dma_pack_pkg::*;

  eng_state_e       state, state_nx;
  logic             dir_q, pinc_q, minc_q, pfix_q, err_q;
  logic [1:0]       psz_q, msz_q;
  logic [CNT_W-1:0] pcnt_q, pcnt_after;

  // Named events for the assertions
  logic cfg_ok, ev_start, ev_accept, ev_reject;
  logic src_beat, dst_beat, p_beat, m_beat, drain, last_beat;
  logic [2:0]  p_bytes, m_bytes, src_bytes, dst_bytes, fill, off;
  logic [31:0] stage_out, src_data;

  dma_pack_cfg #(.CNT_W(CNT_W)) u_cfg (
    .psize(psize), .msize(msize), .count(count), .cfg_ok(cfg_ok));

  assign ev_start  = start && (state == ST_IDLE);
  assign ev_accept = ev_start && cfg_ok;
  assign ev_reject = ev_start && !cfg_ok;

  assign p_bytes   = size_bytes(psz_q);
  assign m_bytes   = size_bytes(msz_q);
  assign src_bytes = dir_q ? m_bytes : p_bytes;
  assign dst_bytes = dir_q ? p_bytes : m_bytes;
  assign src_data  = dir_q ? m_rdata : p_rdata;

  assign src_beat   = (state == ST_READ)  && (dir_q ? m_ack : p_ack);
  assign dst_beat   = (state == ST_WRITE) && (dir_q ? p_ack : m_ack);
  assign p_beat     = dir_q ? dst_beat : src_beat;
  assign m_beat     = dir_q ? src_beat : dst_beat;
  assign pcnt_after = pcnt_q - CNT_W'(p_beat);
  assign last_beat  = drain && (pcnt_after == '0);

  dma_pack_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .put(src_beat), .put_data(src_data), .put_bytes(src_bytes),
    .take(dst_beat), .take_bytes(dst_bytes),
    .out_data(stage_out), .fill(fill), .off(off), .drain(drain));

  dma_pack_addr #(.AW(AW)) u_paddr (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .base(p_base),
    .step_en(pinc_q), .adv(p_beat), .step(periph_step(psz_q, pfix_q)),
    .addr(p_addr));

  dma_pack_addr #(.AW(AW)) u_maddr (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .base(m_base),
    .step_en(minc_q), .adv(m_beat), .step(m_bytes),
    .addr(m_addr));

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (ev_accept) state_nx = ST_READ;
      ST_READ:  if (src_beat && ({1'b0, fill} + {1'b0, src_bytes} >= {1'b0, dst_bytes}))
                  state_nx = ST_WRITE;
      ST_WRITE: if (dst_beat && drain) state_nx = last_beat ? ST_DONE : ST_READ;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      err_q  <= 1'b0;
      dir_q  <= 1'b0;
      psz_q  <= SZ_BYTE;
      msz_q  <= SZ_BYTE;
      pinc_q <= 1'b0;
      minc_q <= 1'b0;
      pfix_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      state <= state_nx;
      err_q <= ev_reject;
      if (ev_accept) begin
        dir_q  <= dir;
        psz_q  <= psize;
        msz_q  <= msize;
        pinc_q <= pinc;
        minc_q <= minc;
        pfix_q <= pfix;
        pcnt_q <= count;
      end else if (p_beat) begin
        pcnt_q <= pcnt_after;
      end
    end
  end

  assign p_req   = dir_q ? (state == ST_WRITE) : (state == ST_READ);
  assign m_req   = dir_q ? (state == ST_READ)  : (state == ST_WRITE);
  assign p_we    = dir_q;
  assign m_we    = !dir_q;
  assign p_wdata = stage_out;
  assign m_wdata = stage_out;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign cfg_err = err_q;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_req && m_req)); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R11
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!busy && !p_req && !m_req)); // R9
  AST_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE) |-> (({1'b0, fill} - {1'b0, off}) >= {1'b0, dst_bytes})); // R10
  AST_COUNT_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pcnt_q == '0)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state == ST_READ || state == ST_WRITE)) |=> busy); // R12

endmodule

// File: tb/dma_pack_engine_bench.sv
`timescale 1ns/1ps
module dma_pack_engine_bench;
  localparam int AW = 32;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0, pinc = 1'b0, minc = 1'b0, pfix = 1'b0;
  logic [1:0] psize = 2'd0, msize = 2'd0;
  logic [CNT_W-1:0] count = '0;
  logic [AW-1:0] p_base = '0, m_base = '0;
  logic p_req, p_we, m_req, m_we, busy, done, cfg_err;
  logic [AW-1:0] p_addr, m_addr;
  logic [31:0] p_wdata, m_wdata;
  logic [31:0] p_rdata = '0, m_rdata = '0;
  logic p_ack = 1'b0, m_ack = 1'b0;

  always #2.5 clk = ~clk;

  dma_pack_engine #(.AW(AW), .CNT_W(CNT_W)) u_dma_pack_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .psize(psize), .msize(msize),
    .pinc(pinc), .minc(minc), .pfix(pfix), .count(count), .p_base(p_base), .m_base(m_base),
    .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .p_ack(p_ack), .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack), .busy(busy), .done(done), .cfg_err(cfg_err));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model state
  bit t_dir, t_pinc, t_minc, t_pfix;
  int t_ps, t_ms, t_cnt, t_seed;
  logic [AW-1:0] t_pb, t_mb;
  int nsrc, ndst, src_i, dst_j;
  bit active = 0, done_due = 0, busy_due = 0;
  logic [AW-1:0] exp_addr_q[$];
  logic [31:0]   exp_data_q[$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic int nbytes(input int s);
    return 1 << s;
  endfunction

  function automatic logic [7:0] sbyte(input int n);
    return 8'((n * 29 + t_seed * 7 + 3) & 255);
  endfunction

  function automatic logic [AW-1:0] port_addr(input bit periph, input int i);
    int step;
    if (periph) begin
      step = t_pfix ? 4 : nbytes(t_ps);
      return t_pinc ? t_pb + AW'(i * step) : t_pb;
    end
    step = nbytes(t_ms);
    return t_minc ? t_mb + AW'(i * step) : t_mb;
  endfunction

  function automatic logic [31:0] lane_mask(input int b);
    return (b >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * b)) - 32'd1);
  endfunction

  // Cycle-by-cycle port agent and comparison, away from the active edge
  always @(negedge clk) begin
    bit src_req, dst_req;
    int sb, db;
    logic [31:0] w, got;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    p_ack = 1'b0;
    m_ack = 1'b0;
    if (done_due) begin
      chk(done === 1'b1, "R11 done after last beat", 64'(done), 64'd1);
      done_due = 0;
      busy_due = 1;
    end else if (busy_due) begin
      chk(busy === 1'b0 && done === 1'b0, "R11 idle after done", 64'({busy, done}), 64'd0);
      busy_due = 0;
      active = 0;
    end else if (done === 1'b1) begin
      chk(1'b0, "R11 unexpected done", 64'd1, 64'd0);
    end
    if (active && !done_due) begin
      sb = t_dir ? nbytes(t_ms) : nbytes(t_ps);
      db = t_dir ? nbytes(t_ps) : nbytes(t_ms);
      src_req = t_dir ? m_req : p_req;
      dst_req = t_dir ? p_req : m_req;
      if ((src_req || dst_req) && lfsr[1:0] != 2'b00) begin
        if (src_req) begin
          chk(src_i < nsrc, "R4 extra source beat", 64'(src_i), 64'(nsrc));
          got = t_dir ? m_addr : p_addr;
          chk(got === port_addr(!t_dir, src_i), "R5/R6/R7/R8 source address",
              64'(got), 64'(port_addr(!t_dir, src_i)));
          chk((t_dir ? m_we : p_we) === 1'b0, "R13 source is read", 64'(t_dir ? m_we : p_we), 64'd0);
          w = 32'hEEEE_EEEE;
          for (int b = 0; b < sb; b++) w[8*b +: 8] = sbyte(src_i * sb + b);
          if (t_dir) begin m_rdata = w; m_ack = 1'b1; end
          else       begin p_rdata = w; p_ack = 1'b1; end
          src_i++;
        end else begin
          chk(dst_j < ndst && exp_addr_q.size() > 0, "R4 extra destination beat", 64'(dst_j), 64'(ndst));
          if (exp_addr_q.size() > 0) begin
            got = t_dir ? p_addr : m_addr;
            chk(got === exp_addr_q[0], "R5/R6/R7/R8 destination address", 64'(got), 64'(exp_addr_q[0]));
            got = (t_dir ? p_wdata : m_wdata) & lane_mask(db);
            chk(got === exp_data_q[0], "R1/R2/R3 destination data", 64'(got), 64'(exp_data_q[0]));
            chk((t_dir ? p_we : m_we) === 1'b1, "R13 destination is write", 64'(t_dir ? p_we : m_we), 64'd1);
            void'(exp_addr_q.pop_front());
            void'(exp_data_q.pop_front());
          end
          if (t_dir) p_ack = 1'b1; else m_ack = 1'b1;
          dst_j++;
          if (dst_j == ndst) done_due = 1;
        end
      end
    end
  end

  task automatic run(input bit d, input int ps, input int ms, input bit pi, input bit mi,
                     input bit pf, input int cnt, input logic [AW-1:0] pb,
                     input logic [AW-1:0] mb, input int seed, input bit poke);
    int total, sb, db, w;
    logic [31:0] word;
    t_dir = d; t_ps = ps; t_ms = ms; t_pinc = pi; t_minc = mi; t_pfix = pf;
    t_cnt = cnt; t_pb = pb; t_mb = mb; t_seed = seed;
    sb = d ? nbytes(ms) : nbytes(ps);
    db = d ? nbytes(ps) : nbytes(ms);
    total = cnt * nbytes(ps);
    nsrc = total / sb;
    ndst = total / db;
    src_i = 0; dst_j = 0;
    exp_addr_q.delete();
    exp_data_q.delete();
    for (int j = 0; j < ndst; j++) begin
      word = '0;
      for (int b = 0; b < db; b++) word[8*b +: 8] = sbyte(j * db + b);
      exp_data_q.push_back(word);
      exp_addr_q.push_back(port_addr(d, j));
    end
    @(negedge clk);
    dir = d; psize = 2'(ps); msize = 2'(ms); pinc = pi; minc = mi; pfix = pf;
    count = CNT_W'(cnt); p_base = pb; m_base = mb; start = 1'b1;
    active = 1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && cfg_err === 1'b0, "R4 accepted start", 64'({busy, cfg_err}), 64'd2);
    if (poke) begin
      repeat (3) @(negedge clk);
      dir = ~d; psize = 2'd2; msize = 2'd0; pinc = ~pi; minc = ~mi; pfix = ~pf;
      count = CNT_W'(1); p_base = 32'hDEAD_0000; m_base = 32'hBEEF_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R12 start ignored while busy", 64'(busy), 64'd1);
    end
    w = 0;
    while (active && w < 4000) begin
      @(negedge clk);
      w++;
    end
    if (active) begin
      chk(1'b0, "R11 transfer did not finish", 64'(dst_j), 64'(ndst));
      active = 0; done_due = 0; busy_due = 0;
    end
    chk(src_i == nsrc, "R4 source beat total", 64'(src_i), 64'(nsrc));
    chk(dst_j == ndst, "R4 destination beat total", 64'(dst_j), 64'(ndst));
  endtask

  task automatic run_bad(input int ps, input int ms, input int cnt);
    @(negedge clk);
    dir = 1'b0; psize = 2'(ps); msize = 2'(ms); pinc = 1'b1; minc = 1'b1; pfix = 1'b0;
    count = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err === 1'b1 && busy === 1'b0, "R9 rejection pulse", 64'({cfg_err, busy}), 64'd2);
    @(negedge clk);
    chk(cfg_err === 1'b0, "R9 rejection lasts one cycle", 64'(cfg_err), 64'd0);
    for (int k = 0; k < 4; k++) begin
      chk(!p_req && !m_req && !busy, "R9 no request after rejection", 64'({p_req, m_req, busy}), 64'd0);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cfg_err && !p_req && !m_req, "R14 reset state",
        64'({busy, done, cfg_err, p_req, m_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !p_req && !m_req, "R14 idle after reset", 64'({busy, p_req, m_req}), 64'd0);

    run(0, 0, 2, 1, 1, 1, 8, 32'h4000_0000, 32'h2000_0100, 1, 0);  // R2 R5 pack bytes to words
    run(0, 0, 1, 1, 1, 0, 6, 32'h4000_0010, 32'h2000_0200, 2, 0);  // R2 R6
    run(0, 1, 0, 1, 1, 0, 3, 32'h4000_0020, 32'h2000_0300, 3, 0);  // R3 unpack halves
    run(1, 0, 2, 1, 1, 0, 8, 32'h4000_0030, 32'h2000_0400, 4, 0);  // R3 R13 word to bytes
    run(1, 2, 0, 1, 1, 1, 2, 32'h4000_0040, 32'h2000_0500, 5, 0);  // R2 R13 bytes to word
    run(0, 2, 2, 0, 1, 0, 3, 32'h4000_0050, 32'h2000_0600, 6, 0);  // R8 fixed periph
    run(1, 1, 1, 1, 0, 1, 4, 32'h4000_0060, 32'h2000_0700, 7, 0);  // R8 fixed mem, R5
    run(0, 0, 2, 1, 1, 0, 12, 32'h4000_0070, 32'h2000_0800, 8, 1); // R12 poke
    run(1, 1, 2, 1, 1, 1, 6, 32'h4000_0080, 32'h2000_0900, 9, 1);  // R12 poke

    run_bad(0, 2, 6);   // R9 not a multiple of 4
    run_bad(1, 2, 3);   // R9 not a multiple of 2
    run_bad(0, 1, 0);   // R9 zero count
    run_bad(3, 0, 4);   // R9 illegal size code
    run_bad(0, 3, 4);   // R9 illegal size code

    for (int ps = 0; ps < 3; ps++) begin      // R1 all nine pairings
      for (int ms = 0; ms < 3; ms++) begin
        run(((ps + ms) % 2) == 1, ps, ms, 1, 1, ps == 0, 4,
            32'h4100_0000 + 32'(ps * 256), 32'h2100_0000 + 32'(ms * 256), 10 + ps * 3 + ms, 0);
      end
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule